// File: doc/BRIEF.md
# Audio Ring Buffer Pointer and Watermark Tracker

This block keeps the bookkeeping for one audio ring buffer held in memory. Software programs the buffer's first and last byte addresses, a watermark threshold and both pointers through a simple write port. A streaming engine asks, one sample word at a time, to move the pointer that the hardware owns. In playback that is the read pointer, and in capture it is the write pointer. The block accepts or refuses each request and moves the pointer. It wraps the pointer back to the base when it passes the last byte.

Each pointer carries a wrap flag in its top bit, so a full buffer and an empty one have different pointer values. From the two pointers the block derives its level: free bytes in playback, filled bytes in capture. When the level goes above the threshold, the block latches a watermark flag once. Software clears the flag and arms it again with a rearm pulse, usually after it has refilled the buffer (playback) or drained it (capture). The block also reports when the engine asks to read an empty buffer (playback) or to write a full one (capture).

Top module: `rbuf_mark_tracker`

## Requirements
- R1: Pointers are 32 bits: bit 31 is a wrap flag and bits 30:0 are a byte address. `cfg_sel` picks the target of a write: 0 base, 1 last byte address (end), 2 threshold, 3 read pointer, 4 write pointer. A write with `cfg_we` high is visible from the next cycle. After reset all registers are zero and all flags are low.
- R2: `is_empty` is high exactly when the read and write pointers are equal. `is_full` is high exactly when they differ only in bit 31.
- R3: Size is end minus base plus one. `level` is the filled byte count in capture and size minus that count in playback.
- R4: `eng_ack` is `eng_req` unless the request is refused. An accepted request moves the hardware-owned pointer forward by 4 bytes on the next edge.
- R5: When an advance would go past the end address, the pointer reloads the base address and toggles bit 31.
- R6: In playback, a request while empty is refused. The read pointer keeps its value, and `xrun_err` is high for the following cycle only.
- R7: In capture, a request while full is refused. The write pointer keeps its value, and `xrun_err` is high for the following cycle only.
- R8: If the tracker is armed and `level` is strictly greater than the threshold at an edge, `mark_flag` is high after that edge. A level equal to the threshold never sets it.
- R9: Setting `mark_flag` disarms the tracker. The flag stays high until `rearm`, which clears the flag on the next edge and arms the tracker. The tracker starts disarmed after reset.
- R10: `position` is the address of the hardware-owned pointer minus the base address, with bit 31 of both ignored.
- R11: A software write to the software-owned pointer changes `is_empty`, `is_full` and `level` from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Software register write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| rearm | input | 1 | Clears the watermark flag and arms the tracker |
| eng_req | input | 1 | Streaming engine asks to move one word |
| eng_ack | output | 1 | The request is accepted this cycle |
| rd_ptr | output | 32 | Read pointer |
| wr_ptr | output | 32 | Write pointer |
| level | output | 32 | Free bytes (playback) or filled bytes (capture) |
| position | output | 32 | Offset of the hardware pointer from the base |
| is_empty | output | 1 | Pointers equal |
| is_full | output | 1 | Pointers differ only in the wrap bit |
| mark_flag | output | 1 | Latched watermark event |
| xrun_err | output | 1 | Underflow (playback) or overflow (capture) pulse |

## Verification
The bench moves the level up to exactly the threshold and then one word past it. A design that compares with greater-or-equal would raise the flag one word too early. It runs the hardware pointer across the end address and checks the reloaded base and the toggled wrap bit. A wrong reload would also show up as a wrong level and position. It asks for a word on an empty playback buffer and on a full capture buffer. A design that lets these requests through would move the pointer and corrupt the full/empty state. Finally it refills and drains through software pointer writes and checks that the flag holds until rearm and fires again only after rearm. A design that keeps the flag armed would fire repeatedly.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  parameter int PTR_W = 32;
  localparam int MSB = PTR_W - 1;
  typedef logic [PTR_W-1:0] ptr_t;

  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_END  = 3'd1,
    SEL_MARK = 3'd2,
    SEL_RD   = 3'd3,
    SEL_WR   = 3'd4
  } cfg_sel_e;

  // address part of a pointer, wrap flag cleared
  function automatic ptr_t addr_of(input ptr_t p);
    return {1'b0, p[MSB-1:0]};
  endfunction

  // pointer after one step, with wrap back to base
  function automatic ptr_t next_ptr(input ptr_t p, input ptr_t base,
                                    input ptr_t endp, input ptr_t step);
    ptr_t a;
    a = addr_of(p) + step;
    if (a > addr_of(endp)) return {~p[MSB], base[MSB-1:0]};
    return {p[MSB], a[MSB-1:0]};
  endfunction

  function automatic ptr_t buf_size(input ptr_t base, input ptr_t endp);
    return addr_of(endp) - addr_of(base) + 1;
  endfunction

  // bytes held between read and write pointer
  function automatic ptr_t fill_bytes(input ptr_t rd, input ptr_t wr,
                                      input ptr_t base, input ptr_t endp);
    if (rd[MSB] == wr[MSB]) return addr_of(wr) - addr_of(rd);
    return buf_size(base, endp) - (addr_of(rd) - addr_of(wr));
  endfunction
endpackage

// File: rtl/rbuf_ptr_reg.sv
module rbuf_ptr_reg
  import rbuf_pkg::*;
#(
  parameter int STEP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_we,
  input  ptr_t sw_val,
  input  logic adv,
  input  ptr_t base,
  input  ptr_t endp,
  output ptr_t ptr
);
  localparam ptr_t STEP_P = ptr_t'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (sw_we)  ptr <= sw_val;
    else if (adv)    ptr <= next_ptr(ptr, base, endp, STEP_P);
  end
endmodule

// File: rtl/rbuf_level.sv
module rbuf_level
  import rbuf_pkg::*;
#(
  parameter bit IS_PLAY = 1'b1
) (
  input  ptr_t rd,
  input  ptr_t wr,
  input  ptr_t base,
  input  ptr_t endp,
  input  ptr_t thresh,
  output ptr_t level,
  output logic empty,
  output logic full,
  output logic over_mark,
  output logic blocked
);
  localparam ptr_t FLIP = ptr_t'(1) << MSB;

  ptr_t filled;

  always_comb begin
    filled    = fill_bytes(rd, wr, base, endp);
    empty     = (rd == wr);
    full      = ((rd ^ wr) == FLIP);
    level     = IS_PLAY ? (buf_size(base, endp) - filled) : filled;
    over_mark = (level > thresh);
    blocked   = IS_PLAY ? empty : full;
  end
endmodule

// File: rtl/rbuf_mark.sv
module rbuf_mark (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic over,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      flag  <= 1'b0;
    end else if (rearm) begin
      armed <= 1'b1;
      flag  <= 1'b0;
    end else if (armed && over) begin
      armed <= 1'b0;
      flag  <= 1'b1;
    end
  end

  // R9
  mark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !rearm |=> flag);
  // R9
  mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !flag);
  // R8
  mark_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(over));
endmodule

// File: rtl/rbuf_mark_tracker.sv
module rbuf_mark_tracker
  import rbuf_pkg::*;
#(
  parameter bit IS_PLAY = 1'b1,
  parameter int STEP    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        rearm,
  input  logic        eng_req,
  output logic        eng_ack,
  output logic [31:0] rd_ptr,
  output logic [31:0] wr_ptr,
  output logic [31:0] level,
  output logic [31:0] position,
  output logic        is_empty,
  output logic        is_full,
  output logic        mark_flag,
  output logic        xrun_err
);
  localparam cfg_sel_e HW_SEL = IS_PLAY ? SEL_RD : SEL_WR;

  ptr_t base_q, end_q, thr_q, hw_ptr;
  logic blocked, over_mark;
  logic adv_rd, adv_wr, hw_sw_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      end_q  <= '0;
      thr_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_BASE: base_q <= cfg_wdata;
        SEL_END:  end_q  <= cfg_wdata;
        SEL_MARK: thr_q  <= cfg_wdata;
        default:  ;
      endcase
    end
  end

  assign eng_ack  = eng_req && !blocked;
  assign hw_sw_we = cfg_we && (cfg_sel == HW_SEL);

  generate
    if (IS_PLAY) begin : g_play
      assign adv_rd = eng_ack;
      assign adv_wr = 1'b0;
      assign hw_ptr = rd_ptr;
    end else begin : g_cap
      assign adv_rd = 1'b0;
      assign adv_wr = eng_ack;
      assign hw_ptr = wr_ptr;
    end
  endgenerate

  rbuf_ptr_reg #(.STEP(STEP)) u_rd (
    .clk(clk), .rst_n(rst_n), .sw_we(cfg_we && cfg_sel == SEL_RD),
    .sw_val(cfg_wdata), .adv(adv_rd), .base(base_q), .endp(end_q), .ptr(rd_ptr));

  rbuf_ptr_reg #(.STEP(STEP)) u_wr (
    .clk(clk), .rst_n(rst_n), .sw_we(cfg_we && cfg_sel == SEL_WR),
    .sw_val(cfg_wdata), .adv(adv_wr), .base(base_q), .endp(end_q), .ptr(wr_ptr));

  rbuf_level #(.IS_PLAY(IS_PLAY)) u_lvl (
    .rd(rd_ptr), .wr(wr_ptr), .base(base_q), .endp(end_q), .thresh(thr_q),
    .level(level), .empty(is_empty), .full(is_full),
    .over_mark(over_mark), .blocked(blocked));

  rbuf_mark u_mark (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .over(over_mark), .flag(mark_flag));

  assign position = addr_of(hw_ptr) - addr_of(base_q);

  always_ff @(posedge clk) begin
    if (!rst_n) xrun_err <= 1'b0;
    else        xrun_err <= eng_req && blocked;
  end

  // R6 R7
  refused_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_ack && !hw_sw_we |=> $stable(hw_ptr));
  // R6 R7
  xrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_ack |=> xrun_err);
  // R4 R5
  advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ack && !hw_sw_we && !cfg_we |=>
      ((addr_of(hw_ptr) == addr_of($past(hw_ptr)) + ptr_t'(STEP)) &&
       (hw_ptr[MSB] == $past(hw_ptr[MSB]))) ||
      ((addr_of(hw_ptr) == addr_of(base_q)) && (hw_ptr[MSB] != $past(hw_ptr[MSB]))));
  // R2
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_empty && is_full));
endmodule

// File: tb/rbuf_mark_tracker_test.sv
module rbuf_mark_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        p_we = 0, p_rearm = 0, p_req = 0;
  logic [2:0]  p_sel = 0;
  logic [31:0] p_wd = 0;
  logic        p_ack, p_empty, p_full, p_mark, p_xrun;
  logic [31:0] p_rd, p_wr, p_lvl, p_pos;

  logic        c_we = 0, c_rearm = 0, c_req = 0;
  logic [2:0]  c_sel = 0;
  logic [31:0] c_wd = 0;
  logic        c_ack, c_empty, c_full, c_mark, c_xrun;
  logic [31:0] c_rd, c_wr, c_lvl, c_pos;

  rbuf_mark_tracker #(.IS_PLAY(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(p_we), .cfg_sel(p_sel), .cfg_wdata(p_wd),
    .rearm(p_rearm), .eng_req(p_req), .eng_ack(p_ack), .rd_ptr(p_rd), .wr_ptr(p_wr),
    .level(p_lvl), .position(p_pos), .is_empty(p_empty), .is_full(p_full),
    .mark_flag(p_mark), .xrun_err(p_xrun));

  rbuf_mark_tracker #(.IS_PLAY(1'b0)) uut_cap (
    .clk(clk), .rst_n(rst_n), .cfg_we(c_we), .cfg_sel(c_sel), .cfg_wdata(c_wd),
    .rearm(c_rearm), .eng_req(c_req), .eng_ack(c_ack), .rd_ptr(c_rd), .wr_ptr(c_wr),
    .level(c_lvl), .position(c_pos), .is_empty(c_empty), .is_full(c_full),
    .mark_flag(c_mark), .xrun_err(c_xrun));

  // field codes: 0 level 1 position 2 empty 3 full 4 mark 5 xrun 6 ack 7 rd 8 wr;
  // +10 selects the capture instance
  typedef struct {
    string       tag;
    int          fld;
    logic [31:0] exp;
  } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [31:0] sample(input int f);
    case (f)
      0: return p_lvl;   1: return p_pos;  2: return 32'(p_empty);
      3: return 32'(p_full); 4: return 32'(p_mark); 5: return 32'(p_xrun);
      6: return 32'(p_ack);  7: return p_rd;    8: return p_wr;
      10: return c_lvl;  11: return c_pos; 12: return 32'(c_empty);
      13: return 32'(c_full); 14: return 32'(c_mark); 15: return 32'(c_xrun);
      16: return 32'(c_ack);  17: return c_rd;   18: return c_wr;
      default: return 32'hdead_beef;
    endcase
  endfunction

  // monitor: compare pending expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = sample(it.fld);
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s field %0d: actual %h expected %h", it.tag, it.fld, act, it.exp);
      end
    end
  end

  task automatic expect_v(input string tag, input int fld, input logic [31:0] exp);
    item_t it;
    it.tag = tag; it.fld = fld; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic p_cfg(input logic [2:0] s, input logic [31:0] d);
    p_we = 1; p_sel = s; p_wd = d; step(); p_we = 0;
  endtask

  task automatic c_cfg(input logic [2:0] s, input logic [31:0] d);
    c_we = 1; c_sel = s; c_wd = d; step(); c_we = 0;
  endtask

  task automatic p_reads(input int n);
    p_req = 1; repeat (n) step(); p_req = 0;
  endtask

  task automatic c_writes(input int n);
    c_req = 1; repeat (n) step(); c_req = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    expect_v("R1 reset rd", 7, 0);
    expect_v("R1 reset wr", 8, 0);
    expect_v("R1 reset mark", 4, 0);
    expect_v("R2 reset empty", 2, 1);
    expect_v("R1 reset cap mark", 14, 0);
    expect_v("R1 reset cap xrun", 15, 0);
    rst_n = 1; step();

    // ---------------- playback: 1 KiB at 0x1000, threshold 256
    p_cfg(0, 32'h0000_1000);
    p_cfg(1, 32'h0000_13FF);
    p_cfg(2, 32'h0000_0100);
    p_cfg(3, 32'h0000_1000);
    p_cfg(4, 32'h8000_1000);
    expect_v("R2 full after init", 3, 1);
    expect_v("R2 not empty", 2, 0);
    expect_v("R3 free zero when full", 0, 0);
    expect_v("R10 position zero", 1, 0);
    p_rearm = 1; step(); p_rearm = 0;
    expect_v("R9 armed, no flag", 4, 0);
    p_req = 1;
    expect_v("R4 ack when data", 6, 1);
    repeat (64) step(); p_req = 0;
    expect_v("R4 rd moved 256", 7, 32'h0000_1100);
    expect_v("R3 free 256", 0, 256);
    step();
    expect_v("R8 equal level does not fire", 4, 0);
    p_reads(1);
    expect_v("R3 free 260", 0, 260);
    step();
    expect_v("R8 fire above threshold", 4, 1);
    expect_v("R10 position 0x104", 1, 32'h104);
    // refill via software write: flag holds
    p_cfg(4, 32'h8000_1104);
    expect_v("R11 full after sw write", 3, 1);
    expect_v("R11 free zero after sw write", 0, 0);
    expect_v("R9 flag held without rearm", 4, 1);
    p_rearm = 1; step(); p_rearm = 0;
    expect_v("R9 rearm clears flag", 4, 0);
    step();
    expect_v("R9 stays clear below threshold", 4, 0);
    // run across the end
    p_reads(191);
    expect_v("R5 wrap to base with flag toggled", 7, 32'h8000_1000);
    expect_v("R10 position after wrap", 1, 0);
    expect_v("R3 free after wrap", 0, 764);
    expect_v("R9 fires again after rearm", 4, 1);
    p_reads(65);
    expect_v("R2 empty after drain", 2, 1);
    expect_v("R3 free equals size", 0, 1024);
    expect_v("R10 position 0x104 after wrap", 1, 32'h104);
    expect_v("R6 no xrun yet", 5, 0);
    step();
    // underflow
    p_req = 1;
    expect_v("R6 refused on empty", 6, 0);
    step(); p_req = 0;
    expect_v("R6 underflow flagged", 5, 1);
    expect_v("R6 rd unchanged", 7, 32'h8000_1104);
    step();
    expect_v("R6 xrun one cycle", 5, 0);

    // ---------------- capture: 256 B at 0x2000, threshold 0
    c_cfg(0, 32'h0000_2000);
    c_cfg(1, 32'h0000_20FF);
    c_cfg(2, 32'h0000_0000);
    c_cfg(3, 32'h0000_2000);
    c_cfg(4, 32'h0000_2000);
    expect_v("R2 cap empty", 12, 1);
    expect_v("R3 cap level zero", 10, 0);
    c_rearm = 1; step(); c_rearm = 0;
    step();
    expect_v("R8 cap zero level equals threshold", 14, 0);
    c_writes(1);
    expect_v("R3 cap filled 4", 10, 4);
    expect_v("R8 not yet visible", 14, 0);
    step();
    expect_v("R8 cap fire", 14, 1);
    c_writes(63);
    expect_v("R5 cap wrap", 18, 32'h8000_2000);
    expect_v("R2 cap full", 13, 1);
    expect_v("R3 cap filled 256", 10, 256);
    expect_v("R10 cap position 0", 11, 0);
    c_req = 1;
    expect_v("R7 refused on full", 16, 0);
    step(); c_req = 0;
    expect_v("R7 overflow flagged", 15, 1);
    expect_v("R7 wr unchanged", 18, 32'h8000_2000);
    step();
    expect_v("R7 xrun one cycle", 15, 0);
    c_cfg(3, 32'h8000_2000);
    expect_v("R11 cap empty after sw read", 12, 1);
    expect_v("R11 cap level zero", 10, 0);
    expect_v("R9 cap flag held", 14, 1);
    step(); step();
    done = 1;
    finish_run();
  end
endmodule